// File: doc/BRIEF.md
# Read-Modify-Write I/O Double-Write Restorer

This block sits on the bus between a CMOS 6502-family processor and the peripheral select logic. A CMOS core runs a read-modify-write instruction as read, dummy read, write. An NMOS core runs it as read, write of the old value, write of the new value. Some software clears peripheral interrupt flags by relying on that NMOS double write, for example an increment of the video chip's interrupt latch. The block watches every opcode fetch and notes whether the instruction is a shift, rotate, increment or decrement of memory. When the write of such an instruction hits one of three trapped I/O registers, the block rebuilds the NMOS write pair on the peripheral side.

The first write of the pair carries the value captured from the instruction's first read of that register. For that cycle the block stalls the processor, which holds its bus cycle unchanged. In the next cycle the processor's own modified value goes out as the second write. All other traffic passes through with no change and no stall.

Top module: `rmw_io_trap`

## Requirements
- R1: While reset is held, and on the first cycle after it, the stall output is low. The reset clears any captured opcode and any held read value.
- R2: On a cycle with the fetch marker high, the byte on the read data bus is taken as the opcode. It counts as read-modify-write when bits [2:0] are 3'b110 and bits [7:6] are not 2'b10. This covers the zero-page, zero-page indexed, absolute and absolute indexed forms of ASL, ROL, LSR, ROR, DEC and INC. A byte such as 8'h96 is not a read-modify-write opcode.
- R3: Only the addresses 16'hD019, 16'hDC0D and 16'hDD0D are trapped. A write to any other address, even a read-modify-write one such as 16'hD018 or 16'h2000, goes through in its own cycle with the CPU's data and no stall.
- R4: A processor write to a trapped address inside a read-modify-write instruction triggers a replay if a read of that address was already captured in the instruction. In that cycle the peripheral sees a write of the captured unmodified value, and the stall output is high.
- R5: In the cycle after a replay write, the peripheral sees a write of the processor's modified value and the stall output is low. Only one extra write is issued per instruction.
- R6: A write to a trapped address from an instruction that is not read-modify-write (a plain store) passes through in one cycle with the CPU's data and no stall.
- R7: Every fetch cycle replaces the captured opcode and discards the held read value. A stale decode therefore never causes a replay in a later instruction.
- R8: The peripheral address always follows the CPU address. The write strobe is the inverse of the CPU read/write line (1 = read), so read cycles never strobe.
- R9: Only the first read of the trapped address after a fetch is captured. The CMOS dummy read that follows does not replace the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | Processor address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rw_i | input | 1 | Processor read/write, 1 = read |
| cpu_sync_i | input | 1 | Opcode fetch marker |
| bus_rdata_i | input | 8 | Data returned to the processor on reads |
| per_addr_o | output | 16 | Peripheral address |
| per_wdata_o | output | 8 | Peripheral write data |
| per_we_o | output | 1 | Peripheral write strobe |
| cpu_stall_o | output | 1 | Hold request to the processor, one cycle per replay |

## Verification
Two functions can meet in one cycle: the capture of a read value and its replay on the write. The test that provokes this returns a different byte on the CMOS dummy read than on the first read, then checks that the replayed write still carries the first byte and not the dummy one. A second case puts a fetch between the decode and a trapped write, and checks that the new fetch wins over the old arming. A reset asserted during a stalled replay must also drop the stall at once and leave no held value for the next write.

// File: rtl/rmw_io_trap_pkg.sv
package rmw_io_trap_pkg;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_SECOND = 1'b1
  } seq_state_e;

  // Memory shift/rotate/inc/dec: low bits 110, excluding STX/LDX rows (10x)
  function automatic logic is_rmw_opcode(input logic [7:0] op);
    return (op[2:0] == 3'b110) && (op[7:6] != 2'b10);
  endfunction

endpackage

// File: rtl/rmw_opcode_decoder.sv
module rmw_opcode_decoder
  import rmw_io_trap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_i,
  output logic              rmw_o
);
  localparam int OP_W = 8;

  logic [OP_W-1:0] op_byte;

  generate
    if (DATA_W >= OP_W) begin : g_wide
      assign op_byte = op_i[OP_W-1:0];
      if (DATA_W > OP_W) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^op_i[DATA_W-1:OP_W];
      end
    end else begin : g_narrow
      assign op_byte = {{(OP_W-DATA_W){1'b0}}, op_i};
    end
  endgenerate

  assign rmw_o = is_rmw_opcode(op_byte);

endmodule

// File: rtl/trap_addr_match.sv
module trap_addr_match #(
  parameter int                       ADDR_W     = 16,
  parameter int                       N_TRAP     = 3,
  parameter logic [N_TRAP*ADDR_W-1:0] TRAP_ADDRS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [N_TRAP-1:0] hit_vec;

  for (genvar g = 0; g < N_TRAP; g++) begin : g_cmp
    assign hit_vec[g] = (addr_i == TRAP_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  assign hit_o = |hit_vec;

endmodule

// File: rtl/rmw_replay_seq.sv
module rmw_replay_seq
  import rmw_io_trap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              rw_i,
  input  logic              hit_i,
  input  logic              rmw_op_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] per_wdata_o,
  output logic              per_we_o,
  output logic              stall_o
);
  seq_state_e        state_q, state_d;
  logic              armed_q;
  logic              held_ok_q;
  logic [DATA_W-1:0] held_q;
  logic              capture;
  logic              inject;

  assign capture = !sync_i && rw_i && hit_i && armed_q && !held_ok_q;
  assign inject  = !sync_i && !rw_i && hit_i && armed_q && held_ok_q
                   && (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (inject) state_d = SEQ_SECOND;
      SEQ_SECOND: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      armed_q   <= 1'b0;
      held_ok_q <= 1'b0;
      held_q    <= '0;
    end else begin
      state_q <= state_d;
      if (sync_i) begin
        armed_q   <= rmw_op_i;
        held_ok_q <= 1'b0;
      end else if (capture) begin
        held_q    <= rdata_i;
        held_ok_q <= 1'b1;
      end else if (state_q == SEQ_SECOND) begin
        held_ok_q <= 1'b0; // one replay per instruction
      end
    end
  end

  assign stall_o     = inject;
  assign per_we_o    = !rw_i;
  assign per_wdata_o = inject ? held_q : wdata_i;

endmodule

// File: rtl/rmw_io_trap.sv
module rmw_io_trap
  import rmw_io_trap_pkg::*;
#(
  parameter int                       ADDR_W     = 16,
  parameter int                       DATA_W     = 8,
  parameter int                       N_TRAP     = 3,
  parameter logic [N_TRAP*ADDR_W-1:0] TRAP_ADDRS = {16'hDD0D, 16'hDC0D, 16'hD019}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rw_i,
  input  logic              cpu_sync_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  output logic              per_we_o,
  output logic              cpu_stall_o
);
  logic hit;
  logic rmw_op;

  rmw_opcode_decoder #(.DATA_W(DATA_W)) u_dec (
    .op_i  (bus_rdata_i),
    .rmw_o (rmw_op)
  );

  trap_addr_match #(
    .ADDR_W     (ADDR_W),
    .N_TRAP     (N_TRAP),
    .TRAP_ADDRS (TRAP_ADDRS)
  ) u_match (
    .addr_i (cpu_addr_i),
    .hit_o  (hit)
  );

  rmw_replay_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (cpu_sync_i),
    .rw_i        (cpu_rw_i),
    .hit_i       (hit),
    .rmw_op_i    (rmw_op),
    .rdata_i     (bus_rdata_i),
    .wdata_i     (cpu_wdata_i),
    .per_wdata_o (per_wdata_o),
    .per_we_o    (per_we_o),
    .stall_o     (cpu_stall_o)
  );

  assign per_addr_o = cpu_addr_i;

endmodule

// File: rtl/rmw_io_trap_chk.sv
module rmw_io_trap_chk #(
  parameter int                       ADDR_W     = 16,
  parameter int                       DATA_W     = 8,
  parameter int                       N_TRAP     = 3,
  parameter logic [N_TRAP*ADDR_W-1:0] TRAP_ADDRS = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic              cpu_rw_i,
  input logic              cpu_sync_i,
  input logic [ADDR_W-1:0] per_addr_o,
  input logic [DATA_W-1:0] per_wdata_o,
  input logic              per_we_o,
  input logic              cpu_stall_o
);
  logic trapped;
  always_comb begin
    trapped = 1'b0;
    for (int i = 0; i < N_TRAP; i++)
      if (cpu_addr_i == TRAP_ADDRS[i*ADDR_W +: ADDR_W]) trapped = 1'b1;
  end

  p_read_no_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rw_i |-> (!per_we_o && per_addr_o == cpu_addr_i));

  p_stall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |=> !cpu_stall_o);

  p_second_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |=> (per_we_o && per_wdata_o == cpu_wdata_i));

  p_stall_trapped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> (!cpu_rw_i && trapped));

  p_untrapped_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_rw_i && !trapped) |->
      (per_we_o && per_wdata_o == cpu_wdata_i && !cpu_stall_o));

  p_fetch_no_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_sync_i |-> !cpu_stall_o);

  always_comb begin
    if (!rst_ni) a_reset_quiet_r1: assert (!cpu_stall_o);
  end

endmodule

bind rmw_io_trap rmw_io_trap_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .N_TRAP     (N_TRAP),
  .TRAP_ADDRS (TRAP_ADDRS)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_rw_i    (cpu_rw_i),
  .cpu_sync_i  (cpu_sync_i),
  .per_addr_o  (per_addr_o),
  .per_wdata_o (per_wdata_o),
  .per_we_o    (per_we_o),
  .cpu_stall_o (cpu_stall_o)
);

// File: tb/rmw_io_trap_tb_top.sv
module rmw_io_trap_tb_top;
  localparam int CLK_P = 10;
  localparam int N_VEC = 45;

  typedef struct packed {
    logic [3:0]  req;
    logic        sync;
    logic        rw;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic        we;
    logic [7:0]  xd;
    logic        stall;
  } vec_t;

  // One entry per bus cycle; tags R2..R9 per comment
  localparam vec_t VECS [N_VEC] = '{
    '{4'd2,1'b1,1'b1,16'h1000,8'h00,8'hEE,1'b0,8'h00,1'b0}, // R2 INC abs fetch
    '{4'd8,1'b0,1'b1,16'h1001,8'h00,8'h19,1'b0,8'h00,1'b0}, // R8
    '{4'd8,1'b0,1'b1,16'h1002,8'h00,8'hD0,1'b0,8'h00,1'b0},
    '{4'd4,1'b0,1'b1,16'hD019,8'h00,8'h81,1'b0,8'h00,1'b0}, // R4 first read
    '{4'd9,1'b0,1'b1,16'hD019,8'h00,8'h55,1'b0,8'h00,1'b0}, // R9 dummy read differs
    '{4'd4,1'b0,1'b0,16'hD019,8'h82,8'h00,1'b1,8'h81,1'b1}, // R4 replay old
    '{4'd5,1'b0,1'b0,16'hD019,8'h82,8'h00,1'b1,8'h82,1'b0}, // R5 new value
    '{4'd7,1'b1,1'b1,16'h1003,8'h00,8'hAD,1'b0,8'h00,1'b0}, // R7 LDA abs
    '{4'd8,1'b0,1'b1,16'h1004,8'h00,8'h19,1'b0,8'h00,1'b0},
    '{4'd8,1'b0,1'b1,16'h1005,8'h00,8'hD0,1'b0,8'h00,1'b0},
    '{4'd6,1'b0,1'b1,16'hD019,8'h00,8'h01,1'b0,8'h00,1'b0},
    '{4'd6,1'b1,1'b1,16'h1006,8'h00,8'h8D,1'b0,8'h00,1'b0}, // R6 STA abs
    '{4'd8,1'b0,1'b1,16'h1007,8'h00,8'h19,1'b0,8'h00,1'b0},
    '{4'd8,1'b0,1'b1,16'h1008,8'h00,8'hD0,1'b0,8'h00,1'b0},
    '{4'd6,1'b0,1'b0,16'hD019,8'h01,8'h00,1'b1,8'h01,1'b0}, // R6 no stall
    '{4'd2,1'b1,1'b1,16'h1009,8'h00,8'hCE,1'b0,8'h00,1'b0}, // R2 DEC abs
    '{4'd8,1'b0,1'b1,16'h100A,8'h00,8'h0D,1'b0,8'h00,1'b0},
    '{4'd8,1'b0,1'b1,16'h100B,8'h00,8'hDC,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b1,16'hDC0D,8'h00,8'h10,1'b0,8'h00,1'b0}, // R3
    '{4'd9,1'b0,1'b1,16'hDC0D,8'h00,8'h10,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b0,16'hDC0D,8'h0F,8'h00,1'b1,8'h10,1'b1}, // R3 second trap
    '{4'd5,1'b0,1'b0,16'hDC0D,8'h0F,8'h00,1'b1,8'h0F,1'b0},
    '{4'd2,1'b1,1'b1,16'h100C,8'h00,8'h0E,1'b0,8'h00,1'b0}, // R2 ASL abs
    '{4'd8,1'b0,1'b1,16'h100D,8'h00,8'h00,1'b0,8'h00,1'b0},
    '{4'd8,1'b0,1'b1,16'h100E,8'h00,8'h20,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b1,16'h2000,8'h00,8'h40,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b1,16'h2000,8'h00,8'h40,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b0,16'h2000,8'h80,8'h00,1'b1,8'h80,1'b0}, // R3 untrapped
    '{4'd2,1'b1,1'b1,16'h100F,8'h00,8'h5E,1'b0,8'h00,1'b0}, // R2 LSR abs,X
    '{4'd8,1'b0,1'b1,16'h1010,8'h00,8'h0D,1'b0,8'h00,1'b0},
    '{4'd8,1'b0,1'b1,16'h1011,8'h00,8'hDD,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b1,16'hDD0D,8'h00,8'h33,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b1,16'hDD0D,8'h00,8'h33,1'b0,8'h00,1'b0},
    '{4'd4,1'b0,1'b0,16'hDD0D,8'h19,8'h00,1'b1,8'h33,1'b1}, // R4 third trap
    '{4'd5,1'b0,1'b0,16'hDD0D,8'h19,8'h00,1'b1,8'h19,1'b0},
    '{4'd7,1'b1,1'b1,16'h1012,8'h00,8'h6E,1'b0,8'h00,1'b0}, // R7 ROR fetch
    '{4'd7,1'b1,1'b1,16'h1013,8'h00,8'hAE,1'b0,8'h00,1'b0}, // R7 new fetch disarms
    '{4'd7,1'b0,1'b1,16'hD019,8'h00,8'h07,1'b0,8'h00,1'b0},
    '{4'd7,1'b0,1'b0,16'hD019,8'h07,8'h00,1'b1,8'h07,1'b0}, // R7 no replay
    '{4'd3,1'b1,1'b1,16'h1014,8'h00,8'hEE,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b1,16'hD018,8'h00,8'h11,1'b0,8'h00,1'b0},
    '{4'd3,1'b0,1'b0,16'hD018,8'h12,8'h00,1'b1,8'h12,1'b0}, // R3 near miss
    '{4'd2,1'b1,1'b1,16'h1015,8'h00,8'h96,1'b0,8'h00,1'b0}, // R2 96 not rmw
    '{4'd2,1'b0,1'b1,16'hD019,8'h00,8'h05,1'b0,8'h00,1'b0},
    '{4'd2,1'b0,1'b0,16'hD019,8'h09,8'h00,1'b1,8'h09,1'b0}  // R2 no replay
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = '0;
  logic        cpu_rw_i = 1'b1;
  logic        cpu_sync_i = 1'b0;
  logic [7:0]  bus_rdata_i = '0;
  logic [15:0] per_addr_o;
  logic [7:0]  per_wdata_o;
  logic        per_we_o;
  logic        cpu_stall_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rmw_io_trap dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rw_i    (cpu_rw_i),
    .cpu_sync_i  (cpu_sync_i),
    .bus_rdata_i (bus_rdata_i),
    .per_addr_o  (per_addr_o),
    .per_wdata_o (per_wdata_o),
    .per_we_o    (per_we_o),
    .cpu_stall_o (cpu_stall_o)
  );

  task automatic drive(input logic s, input logic rw, input logic [15:0] a,
                       input logic [7:0] wd, input logic [7:0] rd);
    cpu_sync_i  = s;
    cpu_rw_i    = rw;
    cpu_addr_i  = a;
    cpu_wdata_i = wd;
    bus_rdata_i = rd;
  endtask

  task automatic check(input int req, input logic we, input logic [7:0] xd,
                       input logic st);
    n_vec++;
    if (per_we_o !== we || cpu_stall_o !== st || per_addr_o !== cpu_addr_i ||
        (we && per_wdata_o !== xd)) begin
      n_bad++;
      $display("FAIL R%0d: we=%b data=%h stall=%b addr=%h expected we=%b data=%h stall=%b addr=%h",
               req, per_we_o, per_wdata_o, cpu_stall_o, per_addr_o,
               we, xd, st, cpu_addr_i);
    end
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drive(1'b0, 1'b1, 16'hD019, 8'h00, 8'h00);
    #(CLK_P*2 + 1);
    check(1, 1'b0, 8'h00, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #(CLK_P/2 - 1);
    check(1, 1'b0, 8'h00, 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk_i);
      drive(VECS[i].sync, VECS[i].rw, VECS[i].addr, VECS[i].wd, VECS[i].rd);
      #(CLK_P/2 - 1);
      check(int'(VECS[i].req), VECS[i].we, VECS[i].xd, VECS[i].stall);
    end

    // R1/R7: reset during a stalled replay drops stall and held value
    @(negedge clk_i); drive(1'b1, 1'b1, 16'h1100, 8'h00, 8'hFE); // INC abs,X
    @(negedge clk_i); drive(1'b0, 1'b1, 16'hD019, 8'h00, 8'h44);
    @(negedge clk_i); drive(1'b0, 1'b0, 16'hD019, 8'h45, 8'h00);
    #(CLK_P/2 - 1);
    check(4, 1'b1, 8'h44, 1'b1);
    #2;
    rst_ni = 1'b0;
    #1;
    check(1, 1'b1, 8'h45, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    drive(1'b0, 1'b0, 16'hD019, 8'h46, 8'h00);
    #(CLK_P/2 - 1);
    check(1, 1'b1, 8'h46, 1'b0);

    // R5: a further write after the pair is plain pass-through
    @(negedge clk_i); drive(1'b1, 1'b1, 16'h1200, 8'h00, 8'hE6); // INC zp
    @(negedge clk_i); drive(1'b0, 1'b1, 16'hD019, 8'h00, 8'h20);
    @(negedge clk_i); drive(1'b0, 1'b0, 16'hD019, 8'h21, 8'h00);
    #(CLK_P/2 - 1); check(5, 1'b1, 8'h20, 1'b1);
    @(negedge clk_i); #(CLK_P/2 - 1); check(5, 1'b1, 8'h21, 1'b0);
    @(negedge clk_i); drive(1'b0, 1'b0, 16'hD019, 8'h22, 8'h00);
    #(CLK_P/2 - 1); check(5, 1'b1, 8'h22, 1'b0);

    @(negedge clk_i); drive(1'b1, 1'b1, 16'h1300, 8'h00, 8'hEA);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule